// File: doc/BRIEF.md
# Three-Phase Dead-Band PWM with Frequency-Tracking Carrier

This block turns three signed phase samples into six gate-drive logic signals, one high-side and one low-side line for each half-bridge of a three-phase inverter. A symmetric up/down carrier is shared by all three phases. Each phase compares its sample, offset to an unsigned value and scaled to the current carrier period, against that carrier. The result is a centre-aligned pulse whose width is proportional to the sample.

The carrier period is not a fixed constant. It is read from a reciprocal table indexed by a frequency setting, so that the carrier slows down as the fundamental slows down and the ratio between the two stays fixed. Every entry is the constant `DIVIDEND` divided by (index + 1). The table is computed when the block is elaborated, so no divider exists in hardware. The default dividend is chosen for a carrier-to-fundamental ratio of 51. A new period and new compare values are taken only when the carrier passes through zero.

A dead-band stage follows each phase. It delays every turn-on by a fixed number of clocks and lets every turn-off take effect at once. As a result, the two switches of one leg are never driven together.

Top module: `bridge_pwm_top`

## Requirements
- R1: While `rst_n` is low, all six gate outputs are low.
- R2: In every cycle and for every phase, `gate_hi` and `gate_lo` are never both high.
- R3: An output that is about to assert goes high only after `DEAD_CYC` (16) clocks following the edge of the raw comparison, and an output that deasserts goes low at that edge. A raw level lasting L cycles therefore yields max(0, L − 16) cycles of output, and at least 16 clocks with both outputs low separate any two assertions in one leg.
- R4: For the unsigned index i on `freq_idx`, the carrier period is P = floor(DIVIDEND / (i + 1)). The carrier counts 0, 1, …, P, P−1, …, 1, so one carrier cycle lasts 2·P clocks.
- R5: The period and the three compare values change only when the carrier is at zero. A change of `phase_smp` or `freq_idx` in mid-cycle never gives a pulse whose width belongs to neither the old nor the new setting.
- R6: Each sample s is two's complement, `SAMPLE_W` bits wide, and phase k occupies bits [k·SAMPLE_W +: SAMPLE_W]. The compare value is C = ((s + 2^(SAMPLE_W−1)) · P) >> SAMPLE_W. The raw high-side level is true while counter + C > P, which gives 2·C − 1 clocks per carrier cycle, centred on the carrier peak (0 clocks when C = 0).
- R7: A phase whose compare value is zero (for example the most negative sample) keeps its high side off and its low side on for the whole carrier cycle, with no dead-band gap.
- R8: While `en` is low, all six outputs are low in the same cycle and the carrier is held at zero. After `en` returns high, every output resumes the widths given by R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable; low forces all gates off |
| freq_idx | input | IDX_W | Frequency setting that indexes the period table |
| phase_smp | input | PHASES·SAMPLE_W | Signed sample for each phase, phase 0 in the low bits |
| gate_hi | output | PHASES | High-side drive, one bit per phase |
| gate_lo | output | PHASES | Low-side drive, one bit per phase |

## Verification
The checker assumes that every table entry is at least 2. It also assumes that `en` and the inputs change only between clock edges, so that the internal carrier never sees a period smaller than its current count in mid-cycle. The bench meets both conditions by shrinking the dividend to 1024 with a 64-entry table, which gives periods from 1024 down to 16, and by driving every input on the falling edge. Samples sweep the full signed range in steps of 8, plus the maximum value. Pulse widths are counted only after two whole carrier cycles at the old and new periods, so every measurement window falls inside a steady carrier.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

   // Direction of the shared triangular carrier.
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } bpwm_dir_e;

   // Default dividend: reciprocal constant that keeps the carrier at 51x
   // the fundamental for the intended clock and phase-accumulator scaling.
   localparam int unsigned BPWM_DEF_DIVIDEND = 51000;

endpackage

// File: rtl/bpwm_recip_lut.sv
module bpwm_recip_lut #(
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned PER_W    = 16,
   parameter int unsigned DIVIDEND = 51000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   output logic [PER_W-1:0] period
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [PER_W-1:0] tbl [DEPTH];
   logic [IDX_W-1:0] idx_q;

   // Constant entries: the quotient is folded at elaboration, no divider.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      assign tbl[gi] = PER_W'(DIVIDEND / (gi + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= '0;
      else        idx_q <= idx;
   end

   assign period = tbl[idx_q];

endmodule

// File: rtl/bpwm_carrier.sv
module bpwm_carrier
   import bpwm_pkg::*;
#(
   parameter int unsigned PHASES   = 3,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned PER_W    = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [PER_W-1:0]                 per_in,
   input  logic [PHASES-1:0][SAMPLE_W-1:0]  smp,
   output logic [PHASES-1:0]                raw_hi,
   output logic [PER_W-1:0]                 cnt_o,
   output logic [PER_W-1:0]                 per_o
);
   localparam int unsigned PROD_W = SAMPLE_W + PER_W;
   localparam int unsigned SUM_W  = PER_W + 1;

   logic [PER_W-1:0]              cnt_q;
   logic [PER_W-1:0]              per_q;
   bpwm_dir_e                     dir_q;
   logic [PHASES-1:0][PER_W-1:0]  cmp_q;
   logic [PHASES-1:0][PER_W-1:0]  cmp_d;
   logic                          at_zero;

   assign at_zero = (cnt_q == '0);

   for (genvar g = 0; g < PHASES; g++) begin : g_ph
      logic [SAMPLE_W-1:0] off;
      logic [PROD_W-1:0]   prod;
      logic [SUM_W-1:0]    sum;

      // Two's complement to offset binary: flip the sign bit.
      assign off      = {~smp[g][SAMPLE_W-1], smp[g][SAMPLE_W-2:0]};
      assign prod     = PROD_W'(off) * PROD_W'(per_in);
      assign cmp_d[g] = prod[PROD_W-1:SAMPLE_W];
      assign sum      = SUM_W'(cnt_q) + SUM_W'(cmp_q[g]);
      assign raw_hi[g] = (sum > SUM_W'(per_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         dir_q <= DIR_UP;
         cmp_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
         dir_q <= DIR_UP;
         per_q <= per_in;
         cmp_q <= cmp_d;
      end else if (at_zero) begin
         per_q <= per_in;
         cmp_q <= cmp_d;
         cnt_q <= PER_W'(1);
         dir_q <= DIR_UP;
      end else if (dir_q == DIR_UP) begin
         if (cnt_q == per_q) begin
            dir_q <= DIR_DOWN;
            cnt_q <= cnt_q - PER_W'(1);
         end else begin
            cnt_q <= cnt_q + PER_W'(1);
         end
      end else begin
         cnt_q <= cnt_q - PER_W'(1);
      end
   end

   assign cnt_o = cnt_q;
   assign per_o = per_q;

endmodule

// File: rtl/bpwm_deadband.sv
module bpwm_deadband #(
   parameter int unsigned DEAD_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic raw,
   output logic hi,
   output logic lo
);
   logic raw_q;

   if (DEAD_CYC == 0) begin : g_nodead
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   raw_q <= 1'b0;
         else if (!en) raw_q <= 1'b0;
         else          raw_q <= raw;
      end
      assign hi = en &  raw_q;
      assign lo = en & ~raw_q;
   end else begin : g_dead
      localparam int unsigned DT_W = $clog2(DEAD_CYC + 1);
      logic [DT_W-1:0] dt_q;
      logic            settled;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            raw_q <= 1'b0;
            dt_q  <= '0;
         end else if (!en) begin
            raw_q <= 1'b0;
            dt_q  <= '0;
         end else if (raw != raw_q) begin
            raw_q <= raw;
            dt_q  <= '0;
         end else if (dt_q != DT_W'(DEAD_CYC)) begin
            dt_q  <= dt_q + DT_W'(1);
         end
      end

      assign settled = (dt_q == DT_W'(DEAD_CYC));
      assign hi = en &  raw_q & settled;
      assign lo = en & ~raw_q & settled;
   end

endmodule

// File: rtl/bridge_pwm_top.sv
module bridge_pwm_top
   import bpwm_pkg::*;
#(
   parameter int unsigned PHASES   = 3,
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned PER_W    = 16,
   parameter int unsigned IDX_W    = 6,
   parameter int unsigned DEAD_CYC = 16,
   parameter int unsigned DIVIDEND = BPWM_DEF_DIVIDEND
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             en,
   input  logic [IDX_W-1:0]                 freq_idx,
   input  logic [PHASES-1:0][SAMPLE_W-1:0]  phase_smp,
   output logic [PHASES-1:0]                gate_hi,
   output logic [PHASES-1:0]                gate_lo
);
   localparam int unsigned DEPTH   = 1 << IDX_W;
   localparam int unsigned MIN_PER = DIVIDEND / DEPTH;

   // Elaboration-time parameter checks.
   if (SAMPLE_W < 2) begin : g_bad_sw
      $error("bridge_pwm_top: SAMPLE_W must be at least 2");
   end
   if (PHASES < 1) begin : g_bad_ph
      $error("bridge_pwm_top: PHASES must be at least 1");
   end
   if (DIVIDEND >= (64'd1 << PER_W)) begin : g_bad_div
      $error("bridge_pwm_top: DIVIDEND does not fit in PER_W bits");
   end
   if (MIN_PER < 2) begin : g_bad_min
      $error("bridge_pwm_top: smallest table period must be at least 2");
   end

   logic [PER_W-1:0]  lut_per;
   logic [PER_W-1:0]  car_cnt;
   logic [PER_W-1:0]  car_per;
   logic [PHASES-1:0] raw_hi;

   bpwm_recip_lut #(
      .IDX_W    (IDX_W),
      .PER_W    (PER_W),
      .DIVIDEND (DIVIDEND)
   ) u_lut (
      .clk    (clk),
      .rst_n  (rst_n),
      .idx    (freq_idx),
      .period (lut_per)
   );

   bpwm_carrier #(
      .PHASES   (PHASES),
      .SAMPLE_W (SAMPLE_W),
      .PER_W    (PER_W)
   ) u_car (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .per_in (lut_per),
      .smp    (phase_smp),
      .raw_hi (raw_hi),
      .cnt_o  (car_cnt),
      .per_o  (car_per)
   );

   for (genvar g = 0; g < PHASES; g++) begin : g_leg
      bpwm_deadband #(
         .DEAD_CYC (DEAD_CYC)
      ) u_db (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (en),
         .raw   (raw_hi[g]),
         .hi    (gate_hi[g]),
         .lo    (gate_lo[g])
      );
   end

endmodule

// File: rtl/bridge_pwm_chk.sv
module bridge_pwm_chk #(
   parameter int unsigned PHASES   = 3,
   parameter int unsigned PER_W    = 16,
   parameter int unsigned DEAD_CYC = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [PHASES-1:0] gate_hi,
   input logic [PHASES-1:0] gate_lo,
   input logic [PER_W-1:0]  cnt,
   input logic [PER_W-1:0]  per
);
   localparam int unsigned IDW = $clog2(DEAD_CYC + 2);

   for (genvar g = 0; g < PHASES; g++) begin : g_leg
      logic [IDW-1:0] idle_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            idle_q <= '0;
         else if (gate_hi[g] || gate_lo[g])
            idle_q <= '0;
         else if (idle_q != IDW'(DEAD_CYC))
            idle_q <= idle_q + IDW'(1);
      end

      // R2: complementary outputs of one leg never overlap
      p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !(gate_hi[g] && gate_lo[g]));

      // R3: a turn-on is preceded by the full dead band
      p_dead_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_lo[g]) |-> (idle_q >= IDW'(DEAD_CYC)));

      p_dead_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate_hi[g]) |-> (idle_q >= IDW'(DEAD_CYC)));
   end

   // R8: disabled bridge has all gates off
   p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (gate_hi == '0 && gate_lo == '0));

   // R5: period register moves only out of a zero count
   p_period_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |=> $stable(per));

   // R4: carrier never exceeds its period
   p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per);

   // R8: carrier parked at zero one cycle into a disable
   p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

endmodule

bind bridge_pwm_top bridge_pwm_chk #(
   .PHASES   (PHASES),
   .PER_W    (PER_W),
   .DEAD_CYC (DEAD_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en      (en),
   .gate_hi (gate_hi),
   .gate_lo (gate_lo),
   .cnt     (car_cnt),
   .per     (car_per)
);

// File: tb/bridge_pwm_top_tb_top.sv
module bridge_pwm_top_tb_top;
   localparam int PH   = 3;
   localparam int SW   = 8;
   localparam int PW   = 16;
   localparam int IW   = 6;
   localparam int DEAD = 16;
   localparam int DIV  = 1024;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  en = 1'b0;
   logic [IW-1:0]         freq_idx = '0;
   logic [PH-1:0][SW-1:0] phase_smp = '0;
   logic [PH-1:0]         gate_hi;
   logic [PH-1:0]         gate_lo;

   int checks = 0;
   int fails  = 0;
   int ovl    = 0;
   int prev_p = DIV;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bridge_pwm_top #(
      .PHASES   (PH),
      .SAMPLE_W (SW),
      .PER_W    (PW),
      .IDX_W    (IW),
      .DEAD_CYC (DEAD),
      .DIVIDEND (DIV)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .freq_idx  (freq_idx),
      .phase_smp (phase_smp),
      .gate_hi   (gate_hi),
      .gate_lo   (gate_lo)
   );

   // R2 monitor: count overlapping cycles on any leg
   always @(negedge clk) if ((gate_hi & gate_lo) != '0) ovl++;

   function automatic int e_per(int ix);
      return DIV / (ix + 1);
   endfunction

   function automatic int e_cmp(int s, int p);
      return ((s + 128) * p) >>> 8;
   endfunction

   function automatic int e_hi(int s, int p);
      int c = e_cmp(s, p);
      int l = (c == 0) ? 0 : 2 * c - 1;
      return (l > DEAD) ? l - DEAD : 0;
   endfunction

   function automatic int e_lo(int s, int p);
      int c = e_cmp(s, p);
      int l;
      if (c == 0) return 2 * p;
      l = 2 * p - (2 * c - 1);
      return (l > DEAD) ? l - DEAD : 0;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_tb();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic apply(int s0, int s1, int s2, int ix);
      @(negedge clk);
      phase_smp[0] = SW'(s0);
      phase_smp[1] = SW'(s1);
      phase_smp[2] = SW'(s2);
      freq_idx     = IW'(ix);
   endtask

   // Steady-state widths over one whole carrier cycle (R3, R6, R7).
   task automatic measure(int s0, int s1, int s2, int ix);
      int p = e_per(ix);
      int sv[PH];
      int hc[PH];
      int lc[PH];
      sv[0] = s0; sv[1] = s1; sv[2] = s2;
      apply(s0, s1, s2, ix);
      repeat (2 * prev_p + 2 * p + 8) @(negedge clk);
      for (int k = 0; k < PH; k++) begin hc[k] = 0; lc[k] = 0; end
      repeat (2 * p) begin
         @(negedge clk);
         for (int k = 0; k < PH; k++) begin
            hc[k] += int'(gate_hi[k]);
            lc[k] += int'(gate_lo[k]);
         end
      end
      for (int k = 0; k < PH; k++) begin
         chk(hc[k] == e_hi(sv[k], p), "R6 R3 high width", hc[k], e_hi(sv[k], p));
         chk(lc[k] == e_lo(sv[k], p), "R6 R3 low width", lc[k], e_lo(sv[k], p));
         if (e_cmp(sv[k], p) == 0)
            chk(hc[k] == 0 && lc[k] == 2 * p, "R7 zero compare", lc[k], 2 * p);
      end
      prev_p = p;
   endtask

   // R4: spacing of low-side turn-ons on phase 0 equals 2P.
   task automatic period_check(int ix);
      int p = e_per(ix);
      int t = 0;
      int t0 = -1;
      int dt = -1;
      logic prev;
      apply(0, 0, 0, ix);
      repeat (2 * prev_p + 2 * p + 8) @(negedge clk);
      prev = gate_lo[0];
      while (t < 6 * p && dt < 0) begin
         @(negedge clk);
         t++;
         if (gate_lo[0] && !prev) begin
            if (t0 < 0) t0 = t;
            else        dt = t - t0;
         end
         prev = gate_lo[0];
      end
      chk(dt == 2 * p, "R4 carrier period", dt, 2 * p);
      prev_p = p;
   endtask

   // R5: change a setting in the middle of a high pulse; every whole
   // pulse seen afterwards must match the old or the new width.
   task automatic tear_check(int s_a, int ix_a, int s_b, int ix_b);
      int wa = e_hi(s_a, e_per(ix_a));
      int wb = e_hi(s_b, e_per(ix_b));
      int pmax = (e_per(ix_a) > e_per(ix_b)) ? e_per(ix_a) : e_per(ix_b);
      int run = 0;
      int seen = 0;
      int bad = 0;
      int badw = 0;
      bit rise = 1'b0;
      logic prev;
      apply(s_a, s_a, s_a, ix_a);
      repeat (2 * prev_p + 2 * e_per(ix_a) + 8) @(negedge clk);
      while (!gate_hi[0]) @(negedge clk);
      repeat (4) @(negedge clk);
      phase_smp[0] = SW'(s_b);
      freq_idx     = IW'(ix_b);
      prev = gate_hi[0];
      repeat (8 * pmax) begin
         @(negedge clk);
         if (gate_hi[0] && !prev) begin rise = 1'b1; run = 0; end
         if (gate_hi[0]) run++;
         if (!gate_hi[0] && prev && rise) begin
            seen++;
            if (run != wa && run != wb) begin bad++; badw = run; end
         end
         prev = gate_hi[0];
      end
      chk(bad == 0, "R5 no torn pulse", badw, wb);
      chk(seen >= 3, "R5 pulses observed", seen, 3);
      prev_p = e_per(ix_b);
   endtask

   initial begin
      // R1: reset holds every gate low
      repeat (3) @(negedge clk);
      chk(gate_hi == '0 && gate_lo == '0, "R1 reset low",
          int'({gate_hi, gate_lo}), 0);
      @(negedge clk) rst_n = 1'b1;
      // R8: disabled after reset
      repeat (40) @(negedge clk);
      chk(gate_hi == '0 && gate_lo == '0, "R8 disabled low",
          int'({gate_hi, gate_lo}), 0);
      @(negedge clk) en = 1'b1;

      // R4 periods at several table entries
      period_check(15);
      period_check(63);
      period_check(3);

      // Sweeps over the signed range at several periods (R6, R3, R7)
      foreach (sweep_ix[n]) begin
         for (int k = 0; k < 32; k++) begin
            int s = -128 + 8 * k;
            measure(s, -s - 1, s / 2, sweep_ix[n]);
         end
         measure(127, -128, 0, sweep_ix[n]);
      end
      // Longest period, a few points
      measure(0, 100, -100, 0);
      measure(-128, 127, 64, 0);

      // R5: sample change, then period change, in mid-pulse
      tear_check(64, 15, -32, 15);
      tear_check(0, 15, 0, 7);

      // R8: disable mid-run, then resume
      @(negedge clk) en = 1'b0;
      begin
         int on = 0;
         repeat (20) begin
            #1;
            on += $countones({gate_hi, gate_lo});
            @(negedge clk);
         end
         chk(on == 0, "R8 disable mid-run", on, 0);
      end
      en = 1'b1;
      measure(40, -60, 90, 31);

      // R2: no overlap anywhere in the run
      chk(ovl == 0, "R2 overlap cycles", ovl, 0);

      done = 1'b1;
      finish_tb();
   end

   int sweep_ix[4] = '{63, 31, 15, 3};

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
         finish_tb();
      end
   end

endmodule